// File: doc/BRIEF.md
# PCI Bus Parity Engine

This block produces and checks the even parity bit that travels alongside a 32-bit multiplexed PCI address/data bus and its four active-low command/byte-enable lines. The bus controller tells it, every clock, whether an address phase or a completed data phase is on the bus. It also reports whether the local agent is the initiator or the target, and whether the transfer is a write. From these the engine decides, one clock later, whether to drive PAR or to compare the PAR seen on the bus against its own computed value.

When the local agent receives write data as a target and the parity does not match, a sticky status bit is set. The engine can drive PERR# through a small state machine. It can also raise a one-clock request toward the non-maskable or system-management interrupt path. A PERR# driven by another device on the bus is also reported through that request path. Address decode and the bus protocol sequencing stay in the controller.

The PERR# state machine has three states. ST_IDLE leaves PERR# undriven. ST_DRIVE_LOW drives it low. ST_DRIVE_HIGH drives it high for one clock before release. The transitions are:
- ST_IDLE to ST_DRIVE_LOW on an enabled error.
- ST_DRIVE_LOW to itself on a further enabled error, or else to ST_DRIVE_HIGH.
- ST_DRIVE_HIGH to ST_DRIVE_LOW on an enabled error, or else to ST_IDLE.

Top module: `busparity_engine`

## Requirements
- R1: In the clock after any cycle, par_o equals the XOR of the 36 bits ad_i and cbe_n_i held in that cycle, so the ones among those bits and PAR together are even.
- R2: Every cbe_n_i bit takes part in parity whatever its value; for example, ad_i=0 with cbe_n_i=4'b0001 gives par_o=1.
- R3: par_oe_o is 1 in the clock after addr_phase_i=1 with initiator_i=1; an address phase with initiator_i=0 leaves par_oe_o at 0.
- R4: par_oe_o is 1 in the clock after data_phase_i=1 when initiator_i=1 with write_i=1, or initiator_i=0 with write_i=0; for the other two combinations it stays 0.
- R5: A data phase with initiator_i=0 and write_i=1 is checked by comparing par_i in the next clock against the computed parity. A mismatch sets parerr_sts_o two clocks after the data phase. Data phases of other role/direction combinations are never checked.
- R6: When perr_resp_en_i=1 on a failing check, perr_oe_o=1 with perr_n_o=0 two clocks after the data phase. The clock after that has perr_oe_o=1 with perr_n_o=1, and then PERR# is released. With perr_resp_en_i=0, perr_oe_o stays 0.
- R7: parerr_sts_o stays 1 until status_clr_i=1 is presented; it is 0 the clock after a clear, and a new error in the same clock as the clear wins and leaves it 1.
- R8: Each reportable error gives a one-clock request two clocks after the data phase. The request appears on nmi_req_o when report_smi_i=0 and on smi_req_o when report_smi_i=1, and on neither when report_en_i=0.
- R9: perr_n_i=0 while the engine is not driving PERR# gives a one-clock request (routed as R8) in the next clock and does not change parerr_sts_o.
- R10: After reset, par_oe_o=0, perr_oe_o=0, perr_n_o=1, parerr_sts_o=0, nmi_req_o=0 and smi_req_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | AD_W | Address/data value on the bus this clock |
| cbe_n_i | input | CBE_W | Command/byte-enable lines, active low |
| addr_phase_i | input | 1 | This clock is an address phase |
| data_phase_i | input | 1 | A data phase completes this clock |
| initiator_i | input | 1 | 1 when the local agent initiated the transfer |
| write_i | input | 1 | 1 when the transfer is a write |
| par_i | input | 1 | PAR value sampled from the bus |
| perr_n_i | input | 1 | PERR# value sampled from the bus |
| perr_resp_en_i | input | 1 | Permit driving PERR# on a detected error |
| report_en_i | input | 1 | Global enable for interrupt requests |
| report_smi_i | input | 1 | 1 routes requests to SMI, 0 to NMI |
| status_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| par_o | output | 1 | Parity bit for the previous clock |
| par_oe_o | output | 1 | PAR drive enable |
| perr_n_o | output | 1 | PERR# drive value |
| perr_oe_o | output | 1 | PERR# drive enable |
| parerr_sts_o | output | 1 | Sticky detected-parity-error status |
| nmi_req_o | output | 1 | One-clock NMI request |
| smi_req_o | output | 1 | One-clock SMI request |

## Verification
A stale parity register or a wrong drive-enable decode shows on par_o or par_oe_o in the very next clock. The bench samples that clock for every role and direction. A PERR# state machine stuck in one state shows on perr_oe_o/perr_n_o within two or three clocks of a failing check, or as PERR# never released. A status bit that fails to stick or to clear shows on parerr_sts_o in the clock after the clear strobe. Misrouted or ungated requests show in the same clock as the status change.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int unsigned BP_AD_W  = 32;
    localparam int unsigned BP_CBE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_DRIVE_LOW  = 2'd1,
        ST_DRIVE_HIGH = 2'd2
    } perr_state_e;
endpackage

// File: rtl/bp_parity_tree.sv
module bp_parity_tree #(
    parameter int unsigned W = 36
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    always_comb begin
        odd_o = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            odd_o = odd_o ^ bits_i[i];
        end
    end
endmodule

// File: rtl/bp_phase_pipe.sv
module bp_phase_pipe #(
    parameter int unsigned AD_W  = 32,
    parameter int unsigned CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             addr_phase_i,
    input  logic             data_phase_i,
    input  logic             initiator_i,
    input  logic             write_i,
    input  logic             par_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             err_o
);
    localparam int unsigned SPAN = AD_W + CBE_W;

    logic odd;
    logic drive_now;
    logic check_now;
    logic par_q;
    logic oe_q;
    logic chk_q;

    bp_parity_tree #(.W(SPAN)) u_tree (
        .bits_i ({cbe_n_i, ad_i}),
        .odd_o  (odd)
    );

    // Local agent owns AD: own address phases, initiator writes, target reads.
    assign drive_now = (addr_phase_i & initiator_i)
                     | (data_phase_i & (initiator_i == write_i));
    assign check_now = data_phase_i & ~initiator_i & write_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
            chk_q <= 1'b0;
        end else begin
            par_q <= odd;
            oe_q  <= drive_now;
            chk_q <= check_now;
        end
    end

    assign par_o    = par_q;
    assign par_oe_o = oe_q;
    assign err_o    = chk_q & (par_i != par_q);

    AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase_i && initiator_i) |=> par_oe_o); // R3
    AST_DATA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase_i && (initiator_i == write_i)) |=> par_oe_o); // R4
    AST_NO_SELF_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (!(data_phase_i && !initiator_i && write_i)) |=> !err_o); // R5
endmodule

// File: rtl/bp_perr_fsm.sv
module bp_perr_fsm
    import bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic perr_n_i,
    input  logic perr_resp_en_i,
    input  logic report_en_i,
    input  logic report_smi_i,
    input  logic status_clr_i,
    output logic perr_n_o,
    output logic perr_oe_o,
    output logic sts_o,
    output logic nmi_o,
    output logic smi_o
);
    perr_state_e state_q;
    perr_state_e state_d;
    logic        assert_err;
    logic        ext_ev;
    logic        report_ev;
    logic        sts_q;
    logic        nmi_q;
    logic        smi_q;

    assign assert_err = err_i & perr_resp_en_i;
    assign ext_ev     = ~perr_n_i & (state_q == ST_IDLE);
    assign report_ev  = err_i | ext_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (assert_err) state_d = ST_DRIVE_LOW;
            ST_DRIVE_LOW:  state_d = assert_err ? ST_DRIVE_LOW : ST_DRIVE_HIGH;
            ST_DRIVE_HIGH: state_d = assert_err ? ST_DRIVE_LOW : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        perr_oe_o = 1'b0;
        perr_n_o  = 1'b1;
        unique case (state_q)
            ST_IDLE:       begin perr_oe_o = 1'b0; perr_n_o = 1'b1; end
            ST_DRIVE_LOW:  begin perr_oe_o = 1'b1; perr_n_o = 1'b0; end
            ST_DRIVE_HIGH: begin perr_oe_o = 1'b1; perr_n_o = 1'b1; end
            default:       begin perr_oe_o = 1'b0; perr_n_o = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
            nmi_q <= 1'b0;
            smi_q <= 1'b0;
        end else begin
            sts_q <= err_i | (sts_q & ~status_clr_i);
            nmi_q <= report_ev & report_en_i & ~report_smi_i;
            smi_q <= report_ev & report_en_i & report_smi_i;
        end
    end

    assign sts_o = sts_q;
    assign nmi_o = nmi_q;
    assign smi_o = smi_q;

    AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE_LOW) |=> perr_oe_o); // R6
    AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_resp_en_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R6
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !status_clr_i) |=> sts_o); // R7
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_o, smi_o})); // R8
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !report_en_i |=> (!nmi_o && !smi_o)); // R8
endmodule

// File: rtl/busparity_engine.sv
module busparity_engine #(
    parameter int unsigned AD_W  = bp_pkg::BP_AD_W,
    parameter int unsigned CBE_W = bp_pkg::BP_CBE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             addr_phase_i,
    input  logic             data_phase_i,
    input  logic             initiator_i,
    input  logic             write_i,
    input  logic             par_i,
    input  logic             perr_n_i,
    input  logic             perr_resp_en_i,
    input  logic             report_en_i,
    input  logic             report_smi_i,
    input  logic             status_clr_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_n_o,
    output logic             perr_oe_o,
    output logic             parerr_sts_o,
    output logic             nmi_req_o,
    output logic             smi_req_o
);
    logic check_err;

    bp_phase_pipe #(.AD_W(AD_W), .CBE_W(CBE_W)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_i         (ad_i),
        .cbe_n_i      (cbe_n_i),
        .addr_phase_i (addr_phase_i),
        .data_phase_i (data_phase_i),
        .initiator_i  (initiator_i),
        .write_i      (write_i),
        .par_i        (par_i),
        .par_o        (par_o),
        .par_oe_o     (par_oe_o),
        .err_o        (check_err)
    );

    bp_perr_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .err_i          (check_err),
        .perr_n_i       (perr_n_i),
        .perr_resp_en_i (perr_resp_en_i),
        .report_en_i    (report_en_i),
        .report_smi_i   (report_smi_i),
        .status_clr_i   (status_clr_i),
        .perr_n_o       (perr_n_o),
        .perr_oe_o      (perr_oe_o),
        .sts_o          (parerr_sts_o),
        .nmi_o          (nmi_req_o),
        .smi_o          (smi_req_o)
    );

    AST_STS_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (!parerr_sts_o && !check_err) |=> !parerr_sts_o); // R5
endmodule

// File: tb/sim_busparity_engine.sv
`timescale 1ns/1ps
module sim_busparity_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n_i = '0;
    logic        addr_phase_i = 0, data_phase_i = 0, initiator_i = 0, write_i = 0;
    logic        par_i = 0, perr_n_i = 1, perr_resp_en_i = 1, report_en_i = 1;
    logic        report_smi_i = 0, status_clr_i = 0;
    logic        par_o, par_oe_o, perr_n_o, perr_oe_o, parerr_sts_o, nmi_req_o, smi_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    busparity_engine u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
        .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
        .initiator_i(initiator_i), .write_i(write_i), .par_i(par_i),
        .perr_n_i(perr_n_i), .perr_resp_en_i(perr_resp_en_i),
        .report_en_i(report_en_i), .report_smi_i(report_smi_i),
        .status_clr_i(status_clr_i), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .parerr_sts_o(parerr_sts_o),
        .nmi_req_o(nmi_req_o), .smi_req_o(smi_req_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        addr_phase_i = 0; data_phase_i = 0; initiator_i = 0; write_i = 0;
        ad_i = '0; cbe_n_i = '0; par_i = 0; perr_n_i = 1; status_clr_i = 0;
    endtask

    task automatic clear_status();
        idle();
        status_clr_i = 1;
        step();
        status_clr_i = 0;
        check("R7", "status after clear", parerr_sts_o, 1'b0);
    endtask

    task automatic t_reset();
        check("R10", "par_oe", par_oe_o, 1'b0);
        check("R10", "perr_oe", perr_oe_o, 1'b0);
        check("R10", "perr_n", perr_n_o, 1'b1);
        check("R10", "status", parerr_sts_o, 1'b0);
        check("R10", "nmi", nmi_req_o, 1'b0);
        check("R10", "smi", smi_req_o, 1'b0);
    endtask

    task automatic t_addr_gen();
        logic [31:0] a;
        idle(); addr_phase_i = 1; initiator_i = 1; ad_i = 32'h0000_0001; cbe_n_i = 4'h0;
        step();
        check("R1", "par one bit", par_o, 1'b1);
        check("R3", "oe initiator addr", par_oe_o, 1'b1);
        a = 32'hA5C3_0F71;
        ad_i = a; cbe_n_i = 4'b1011;
        step();
        check("R1", "par mixed", par_o, ^{4'b1011, a});
        idle(); ad_i = 32'hFFFF_FFFF; cbe_n_i = 4'hF; addr_phase_i = 1; initiator_i = 0;
        step();
        check("R1", "par all ones", par_o, 1'b0);
        check("R3", "oe target addr", par_oe_o, 1'b0);
    endtask

    task automatic t_byte_enables();
        idle(); cbe_n_i = 4'b0001;
        step();
        check("R2", "disabled lane counted", par_o, 1'b1);
        cbe_n_i = 4'b1000;
        step();
        check("R2", "upper lane counted", par_o, 1'b1);
        cbe_n_i = 4'b1001;
        step();
        check("R2", "two lanes cancel", par_o, 1'b0);
    endtask

    task automatic t_data_roles();
        for (int k = 0; k < 4; k++) begin
            idle(); data_phase_i = 1; initiator_i = k[1]; write_i = k[0];
            step();
            check("R4", $sformatf("oe init=%0d wr=%0d", k[1], k[0]), par_oe_o, k[1] == k[0]);
        end
        idle(); step();
        check("R4", "oe after idle", par_oe_o, 1'b0);
    endtask

    task automatic t_target_write_error();
        idle(); report_en_i = 1; report_smi_i = 0; perr_resp_en_i = 1;
        data_phase_i = 1; write_i = 1; ad_i = 32'h3; cbe_n_i = 4'h0;
        step();
        check("R5", "status before check", parerr_sts_o, 1'b0);
        idle(); par_i = 1;
        step();
        check("R5", "status set", parerr_sts_o, 1'b1);
        check("R6", "perr driven", perr_oe_o, 1'b1);
        check("R6", "perr low", perr_n_o, 1'b0);
        check("R8", "nmi pulse", nmi_req_o, 1'b1);
        check("R8", "no smi", smi_req_o, 1'b0);
        idle(); step();
        check("R6", "perr still driven", perr_oe_o, 1'b1);
        check("R6", "perr high", perr_n_o, 1'b1);
        check("R8", "nmi one clock", nmi_req_o, 1'b0);
        check("R7", "status sticky", parerr_sts_o, 1'b1);
        step();
        check("R6", "perr released", perr_oe_o, 1'b0);
        clear_status();
    endtask

    task automatic t_good_parity();
        idle(); data_phase_i = 1; write_i = 1; ad_i = 32'h3;
        step();
        idle(); par_i = 0;
        step();
        check("R5", "good parity no status", parerr_sts_o, 1'b0);
        check("R6", "good parity no perr", perr_oe_o, 1'b0);
        check("R8", "good parity no nmi", nmi_req_o, 1'b0);
    endtask

    task automatic t_resp_disabled_smi();
        idle(); perr_resp_en_i = 0; report_smi_i = 1; data_phase_i = 1; write_i = 1; ad_i = 32'h1;
        step();
        idle(); par_i = 0;
        step();
        check("R5", "status with resp off", parerr_sts_o, 1'b1);
        check("R6", "no perr with resp off", perr_oe_o, 1'b0);
        check("R8", "smi pulse", smi_req_o, 1'b1);
        check("R8", "no nmi when smi", nmi_req_o, 1'b0);
        perr_resp_en_i = 1; report_smi_i = 0;
        clear_status();
    endtask

    task automatic t_report_off();
        idle(); report_en_i = 0; data_phase_i = 1; write_i = 1; ad_i = 32'h1;
        step();
        idle(); par_i = 0;
        step();
        check("R8", "no nmi when gated", nmi_req_o, 1'b0);
        check("R8", "no smi when gated", smi_req_o, 1'b0);
        check("R5", "status still set", parerr_sts_o, 1'b1);
        idle(); report_en_i = 1;
        step(); step();
        clear_status();
    endtask

    task automatic t_external_perr();
        idle(); perr_n_i = 0;
        step();
        check("R9", "ext perr nmi", nmi_req_o, 1'b1);
        check("R9", "ext perr no status", parerr_sts_o, 1'b0);
        idle(); step();
        check("R9", "ext pulse ends", nmi_req_o, 1'b0);
    endtask

    task automatic t_other_roles_ignored();
        idle(); data_phase_i = 1; initiator_i = 1; write_i = 0; ad_i = 32'h7;
        step();
        idle(); par_i = 0;
        step();
        check("R5", "initiator read not checked", parerr_sts_o, 1'b0);
        idle(); data_phase_i = 1; initiator_i = 0; write_i = 0; ad_i = 32'h7;
        step();
        idle(); par_i = 0;
        step();
        check("R5", "target read not checked", parerr_sts_o, 1'b0);
    endtask

    task automatic t_clear_priority();
        idle(); data_phase_i = 1; write_i = 1; ad_i = 32'h1;
        step();
        idle(); par_i = 0; status_clr_i = 1;
        step();
        check("R7", "set wins over clear", parerr_sts_o, 1'b1);
        idle(); step(); step();
        clear_status();
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1;
        t_addr_gen();
        t_byte_enables();
        t_data_roles();
        t_target_write_error();
        t_good_parity();
        t_resp_disabled_smi();
        t_report_off();
        t_external_perr();
        t_other_roles_ignored();
        t_clear_priority();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule